// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Once software turns it on, a down-counter runs at a divided clock rate. If software does not restart it in time, the counter expires. The block then raises a sticky timeout flag and can fire a reset pulse, an interrupt pulse, or both. Each pulse lasts a programmable number of divided-clock ticks. After a timeout the counter reloads by itself and keeps running, so an ignored watchdog times out again and again.

Runaway code could clear or reprogram the watchdog by accident. To guard against this, each configuration word must carry a fixed key in a field set aside for it, or the write is dropped. A restart is honoured only when the written word equals one magic value. The bus is single-cycle: a write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. Read data is combinational from the addressed register while `bus_sel` is high, and zero otherwise.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset, all four registers read as zero and both `wdt_rst` and `wdt_irq` are low.
- R2: Mode register (offset 0x0): bit 0 run, bit 1 reset-output enable, bit 2 interrupt-output enable, bits 6:4 reset length code, bits 8:7 interrupt length code. A write updates these fields only when bits 23:12 equal 0xABC. Any other key leaves the register unchanged.
- R3: Control register (offset 0x4): bits 1:0 divider select, bits 13:2 reload value. A write updates these fields only when bits 25:14 equal 0x248. Any other key, including 0xABC placed at bits 23:12, leaves the register unchanged.
- R4: Reads return only the stored fields at their write positions, with key fields and all other bits zero. The restart register (0x8) always reads zero. Status (0xC) reads the flag in bit 0.
- R5: The divider select code c gives a tick every 2^(DIV_BASE+DIV_STEP*c) clocks. With the default parameters this is 8, 64, 512 or 4096. The full reload value is the 12-bit reload field followed by LOW_BITS ones. A timeout happens on the first tick at which the counter is zero, which is (full reload + 1) ticks after the counter was loaded. While the run bit is clear, no timeout happens.
- R6: Writing exactly 0x0000_1999 to offset 0x8 reloads the counter and restarts the divider. Any other value written there is ignored: it changes neither the timing of the next timeout nor the flag.
- R7: The status flag sets at a timeout and stays set until a valid restart write or reset clears it.
- R8: When the reset-output enable is set at a timeout, `wdt_rst` goes high for 2^(code+1) ticks (2 to 256). It never rises while that enable is clear.
- R9: When the interrupt-output enable is set at a timeout, `wdt_irq` goes high for 2^(code+2) ticks (4 to 32). It never rises while that enable is clear.
- R10: After a timeout the counter reloads on its own, so timeouts repeat every (full reload + 1) ticks.
- R11: Clearing the run bit stops counting and no timeout can occur. Setting it again reloads the counter and restarts the divider from zero, so the next timeout is a full period away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_rst | output | 1 | Timeout reset pulse |
| wdt_irq | output | 1 | Timeout interrupt pulse |

## Verification
The assertions check the protection rules on every cycle. A write with a wrong key never changes a configuration register. A wrong restart word never clears a set flag, and a valid one always clears it. The flag cannot move while the timer is stopped. Neither pulse can rise unless its output enable was set, and key fields always read back as zero. Cycle counts cannot be seen from a single cycle, so only the bench scenarios can show them. These are the timeout period for each divider and reload, the length of each pulse code, the repeat period after a timeout, and the full period that follows a restart or a re-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int RELOAD_W = 12;
    localparam int KEY_W    = 12;

    localparam logic [KEY_W-1:0] MODE_KEY  = 12'hABC;
    localparam logic [KEY_W-1:0] CTRL_KEY  = 12'h248;
    localparam logic [31:0]      KICK_WORD = 32'h0000_1999;

    localparam logic [3:0] OFF_MODE = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_KICK = 4'h8;
    localparam logic [3:0] OFF_STAT = 4'hC;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_MODE,
        ACC_CTRL,
        ACC_KICK,
        ACC_STAT
    } acc_t;

    typedef struct packed {
        logic [1:0] irq_len;
        logic [2:0] rst_len;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } mode_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [1:0]          psel;
    } ctrl_t;

    function automatic acc_t decode_addr(logic [3:0] a);
        case (a)
            OFF_MODE: return ACC_MODE;
            OFF_CTRL: return ACC_CTRL;
            OFF_KICK: return ACC_KICK;
            OFF_STAT: return ACC_STAT;
            default:  return ACC_NONE;
        endcase
    endfunction

    function automatic logic [KEY_W-1:0] mode_key_of(logic [31:0] w);
        return w[23:12];
    endfunction

    function automatic logic [KEY_W-1:0] ctrl_key_of(logic [31:0] w);
        return w[25:14];
    endfunction

    function automatic mode_t mode_from_word(logic [31:0] w);
        mode_t m;
        m.run     = w[0];
        m.rst_en  = w[1];
        m.irq_en  = w[2];
        m.rst_len = w[6:4];
        m.irq_len = w[8:7];
        return m;
    endfunction

    function automatic logic [31:0] mode_to_word(mode_t m);
        logic [31:0] w;
        w      = '0;
        w[0]   = m.run;
        w[1]   = m.rst_en;
        w[2]   = m.irq_en;
        w[6:4] = m.rst_len;
        w[8:7] = m.irq_len;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [31:0] w);
        ctrl_t c;
        c.psel   = w[1:0];
        c.reload = w[13:2];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w       = '0;
        w[1:0]  = c.psel;
        w[13:2] = c.reload;
        return w;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        timeout,
    output mode_t       mode_q,
    output ctrl_t       ctrl_q,
    output logic        status_q,
    output logic        kick_ok,
    output logic        arm,
    output logic [31:0] bus_rdata
);

    acc_t  acc;
    mode_t mode_new;
    logic  mode_wr_ok;
    logic  ctrl_wr_ok;

    always_comb begin
        acc        = bus_sel ? decode_addr(bus_addr) : ACC_NONE;
        mode_new   = mode_from_word(bus_wdata);
        mode_wr_ok = bus_wr && (acc == ACC_MODE) && (mode_key_of(bus_wdata) == MODE_KEY);
        ctrl_wr_ok = bus_wr && (acc == ACC_CTRL) && (ctrl_key_of(bus_wdata) == CTRL_KEY);
        kick_ok    = bus_wr && (acc == ACC_KICK) && (bus_wdata == KICK_WORD);
        arm        = mode_wr_ok && mode_new.run && !mode_q.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            ctrl_q   <= '0;
            status_q <= 1'b0;
        end else begin
            if (mode_wr_ok) mode_q <= mode_new;
            if (ctrl_wr_ok) ctrl_q <= ctrl_from_word(bus_wdata);
            if (kick_ok)
                status_q <= 1'b0;
            else if (timeout)
                status_q <= 1'b1;
        end
    end

    always_comb begin
        case (acc)
            ACC_MODE: bus_rdata = mode_to_word(mode_q);
            ACC_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
            ACC_STAT: bus_rdata = {31'b0, status_q};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV_BASE = 3,
    parameter int DIV_STEP = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] psel,
    output logic       tick
);

    localparam int MAX_LOG = DIV_BASE + 3 * DIV_STEP;
    localparam int PW      = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [PW-1:0] lim_tab [4];
    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lim_tab[g] = PW'((64'd1 << (DIV_BASE + DIV_STEP * g)) - 64'd1);
    end

    always_comb begin
        limit = lim_tab[psel];
        tick  = run && (pcnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int LOW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                load,
    input  logic                tick,
    input  logic [RELOAD_W-1:0] reload,
    output logic                timeout
);

    localparam int CW = RELOAD_W + LOW_BITS;

    logic [CW-1:0] cnt;
    logic [CW-1:0] full;

    always_comb begin
        full    = {reload, {LOW_BITS{1'b1}}};
        timeout = run && tick && !load && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= full;
        else if (run && tick)
            cnt <= (cnt == '0) ? full : cnt - 1'b1;
    end

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int CODE_W   = 3,
    parameter int BASE_LOG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              active
);

    localparam int MAX_LOG = (1 << CODE_W) - 1 + BASE_LOG;
    localparam int RW      = MAX_LOG + 1;

    logic [RW-1:0] remain;
    logic [RW-1:0] len;

    always_comb len = RW'(1) << (int'(code) + BASE_LOG);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (start) begin
            active <= 1'b1;
            remain <= len;
        end else if (active && tick) begin
            remain <= remain - 1'b1;
            if (remain == RW'(1)) active <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int LOW_BITS = 12,
    parameter int DIV_BASE = 3,
    parameter int DIV_STEP = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst,
    output logic        wdt_irq
);

    mode_t mode_q;
    ctrl_t ctrl_q;
    logic  status_q;
    logic  kick_ok;
    logic  arm;
    logic  timeout;
    logic  tick;
    logic  rst_busy;
    logic  irq_busy;
    logic  pre_run;
    logic  load;

    always_comb begin
        pre_run = mode_q.run || rst_busy || irq_busy;
        load    = arm || kick_ok;
    end

    wdog_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .timeout   (timeout),
        .mode_q    (mode_q),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q),
        .kick_ok   (kick_ok),
        .arm       (arm),
        .bus_rdata (bus_rdata)
    );

    wdog_prescale #(.DIV_BASE(DIV_BASE), .DIV_STEP(DIV_STEP)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (pre_run),
        .clear (load),
        .psel  (ctrl_q.psel),
        .tick  (tick)
    );

    wdog_countdown #(.LOW_BITS(LOW_BITS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_q.run),
        .load    (load),
        .tick    (tick),
        .reload  (ctrl_q.reload),
        .timeout (timeout)
    );

    wdog_pulse #(.CODE_W(3), .BASE_LOG(1)) u_rst_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (timeout && mode_q.rst_en),
        .tick   (tick),
        .code   (mode_q.rst_len),
        .active (rst_busy)
    );

    wdog_pulse #(.CODE_W(2), .BASE_LOG(2)) u_irq_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (timeout && mode_q.irq_en),
        .tick   (tick),
        .code   (mode_q.irq_len),
        .active (irq_busy)
    );

    assign wdt_rst = rst_busy;
    assign wdt_irq = irq_busy;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input mode_t       mode_q,
    input ctrl_t       ctrl_q,
    input logic        status_q,
    input logic        wdt_rst,
    input logic        wdt_irq
);

    logic wr_mode, wr_ctrl, wr_kick, good_kick;

    always_comb begin
        wr_mode   = bus_sel && bus_wr && (bus_addr == OFF_MODE);
        wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
        wr_kick   = bus_sel && bus_wr && (bus_addr == OFF_KICK);
        good_kick = wr_kick && (bus_wdata == KICK_WORD);
    end

    AST_MODE_KEY_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && bus_wdata[23:12] != MODE_KEY) |=> $stable(mode_q)); // R2

    AST_CTRL_KEY_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[25:14] != CTRL_KEY) |=> $stable(ctrl_q)); // R3

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && (bus_addr == OFF_MODE || bus_addr == OFF_CTRL)) |-> (bus_rdata[31:14] == '0)); // R4

    AST_BAD_KICK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_kick && !good_kick && status_q) |=> status_q); // R6

    AST_KICK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        good_kick |=> !status_q); // R7

    AST_IDLE_FLAG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.run && !good_kick) |=> $stable(status_q)); // R11

    AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst) |-> $past(mode_q.rst_en)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> $past(mode_q.irq_en)); // R9

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> status_q); // R7

endmodule

bind wdog_timer wdog_checker i_wdog_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q),
    .wdt_rst   (wdt_rst),
    .wdt_irq   (wdt_irq)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam int LOWB  = 2;
    localparam int DB    = 1;
    localparam int DS    = 1;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst;
    logic        wdt_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdog_timer #(.LOW_BITS(LOWB), .DIV_BASE(DB), .DIV_STEP(DS)) i_wdog_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mode_word(bit run, bit ren, bit ien, int rlen, int ilen,
                                             logic [11:0] key = 12'hABC);
        return (32'(key) << 12) | (32'(ilen & 3) << 7) | (32'(rlen & 7) << 4)
             | (32'(ien) << 2) | (32'(ren) << 1) | 32'(run);
    endfunction

    function automatic logic [31:0] ctrl_word(int reload, int psel, logic [11:0] key = 12'h248);
        return (32'(key) << 14) | (32'(reload & 12'hFFF) << 2) | 32'(psel & 3);
    endfunction

    function automatic int period(int reload, int psel);
        return (reload * (1 << LOWB) + (1 << LOWB)) * (1 << (DB + DS * psel));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic sample(int which, output bit v);
        logic [31:0] d;
        if (which == 0) begin
            bus_read(4'hC, d);
            v = d[0];
        end else if (which == 1) begin
            v = wdt_rst;
        end else begin
            v = wdt_irq;
        end
    endtask

    task automatic count_until(int which, bit level, output int n);
        bit v;
        n = 0;
        sample(which, v);
        while (v !== level && n < LIMIT) begin
            @(negedge clk);
            n++;
            sample(which, v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        bit v;

        // R1: reset state
        do_reset();
        for (int a = 0; a < 16; a += 4) begin
            bus_read(4'(a), d);
            check("R1", $sformatf("reg 0x%0h after reset", a), d, 0);
        end
        check("R1", "wdt_rst after reset", wdt_rst, 0);
        check("R1", "wdt_irq after reset", wdt_irq, 0);

        // R2: mode key guard
        bus_write(4'h0, mode_word(0, 1, 1, 7, 3, 12'h000));
        bus_read(4'h0, d);
        check("R2", "mode after bad key", d, 0);
        bus_write(4'h0, mode_word(0, 1, 1, 7, 3) | 32'h0F00_0E08);
        bus_read(4'h0, d);
        check("R4", "mode readback masks key and spare bits", d, 32'h1F6);
        bus_write(4'h0, mode_word(0, 0, 0, 0, 0, 12'hABD));
        bus_read(4'h0, d);
        check("R2", "mode unchanged by near-miss key", d, 32'h1F6);

        // R3: control key guard
        bus_write(4'h4, ctrl_word(12'hABC, 2, 12'h247));
        bus_read(4'h4, d);
        check("R3", "ctrl after bad key", d, 0);
        bus_write(4'h4, (32'hABC << 12) | 32'h0000_0AF2);
        bus_read(4'h4, d);
        check("R3", "ctrl ignores mode key", d, 0);
        bus_write(4'h4, ctrl_word(12'hABC, 2));
        bus_read(4'h4, d);
        check("R3", "ctrl after good key", d, 32'h2AF2);

        // R4: restart register reads zero
        bus_write(4'h8, 32'h1999);
        bus_read(4'h8, d);
        check("R4", "restart readback", d, 0);

        // R5: period sweep over divider and reload
        for (int ps = 0; ps < 4; ps++) begin
            for (int rl = 0; rl < 3; rl++) begin
                do_reset();
                bus_write(4'h4, ctrl_word(rl, ps));
                bus_write(4'h0, mode_word(1, 0, 0, 0, 0));
                count_until(0, 1, n);
                check("R5", $sformatf("timeout cycles psel=%0d reload=%0d", ps, rl), n, period(rl, ps));
            end
        end

        // R5/R11: stopped timer never times out
        do_reset();
        bus_write(4'h4, ctrl_word(0, 0));
        bus_write(4'h0, mode_word(0, 1, 1, 0, 0));
        repeat (100) @(negedge clk);
        sample(0, v);
        check("R5", "no timeout while stopped", v, 0);
        check("R11", "no pulses while stopped", wdt_rst | wdt_irq, 0);

        // R8: reset pulse lengths
        for (int c = 0; c < 8; c++) begin
            do_reset();
            bus_write(4'h4, ctrl_word(70, 0));
            bus_write(4'h0, mode_word(1, 1, 0, c, 0));
            count_until(1, 1, n);
            check("R8", $sformatf("rst pulse start code=%0d", c), n, period(70, 0));
            count_until(1, 0, n);
            check("R8", $sformatf("rst pulse width code=%0d", c), n, (2 << c) * (1 << DB));
            check("R9", "irq quiet when disabled", wdt_irq, 0);
        end

        // R9: interrupt pulse lengths
        for (int c = 0; c < 4; c++) begin
            do_reset();
            bus_write(4'h4, ctrl_word(20, 0));
            bus_write(4'h0, mode_word(1, 0, 1, 0, c));
            count_until(2, 1, n);
            check("R9", $sformatf("irq pulse start code=%0d", c), n, period(20, 0));
            check("R8", "rst quiet when disabled", wdt_rst, 0);
            count_until(2, 0, n);
            check("R9", $sformatf("irq pulse width code=%0d", c), n, (4 << c) * (1 << DB));
        end

        // R10: periodic timeouts, R7 sticky flag
        do_reset();
        bus_write(4'h4, ctrl_word(1, 1));
        bus_write(4'h0, mode_word(1, 0, 1, 0, 0));
        count_until(2, 1, n);
        check("R10", "first timeout", n, period(1, 1));
        for (int k = 0; k < 2; k++) begin
            int a, b;
            count_until(2, 0, a);
            count_until(2, 1, b);
            check("R10", $sformatf("repeat period %0d", k), a + b, period(1, 1));
        end
        sample(0, v);
        check("R7", "flag stays set across timeouts", v, 1);

        // R6: bad restart is ignored
        do_reset();
        bus_write(4'h4, ctrl_word(3, 0));
        bus_write(4'h0, mode_word(1, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        bus_write(4'h8, 32'h1998);
        count_until(0, 1, n);
        check("R6", "bad restart keeps timing", n, period(3, 0) - 22);
        bus_write(4'h8, 32'h0001_1999);
        sample(0, v);
        check("R6", "bad restart keeps flag", v, 1);
        bus_write(4'h8, 32'h1999);
        sample(0, v);
        check("R7", "valid restart clears flag", v, 0);

        // R6: valid restart reloads
        do_reset();
        bus_write(4'h4, ctrl_word(3, 0));
        bus_write(4'h0, mode_word(1, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        bus_write(4'h8, 32'h1999);
        count_until(0, 1, n);
        check("R6", "valid restart reloads", n, period(3, 0));

        // R11: stop then re-enable
        do_reset();
        bus_write(4'h4, ctrl_word(3, 0));
        bus_write(4'h0, mode_word(1, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        bus_write(4'h0, mode_word(0, 0, 0, 0, 0));
        repeat (100) @(negedge clk);
        sample(0, v);
        check("R11", "stopped counter holds off timeout", v, 0);
        bus_write(4'h0, mode_word(1, 0, 0, 0, 0));
        count_until(0, 1, n);
        check("R11", "re-enable gives full period", n, period(3, 0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule